// File: doc/BRIEF.md
# Stereo Output Mapper with Soft Mute

This block receives one signed left sample and one signed right sample per audio frame, marked by a valid strobe. It routes them to a left and a right output under a 4-bit mapping code. Each output has its own 2-bit source field. The field can choose silence, the left input, the right input, or the average of the two. With these fields the block gives ordinary stereo, swapped channels, mono and full silence, plus the mixed pairings in between.

After the routing stage, a soft-mute gain scales both outputs. While the mute request is high, the gain falls by one step per frame. While it is low, the gain climbs back toward full scale. Output therefore fades to zero and returns without a step. If the request flips partway through a ramp, the ramp reverses on the next frame. The mapping code and the mute request are sampled only on the cycle that carries a valid frame. A frame leaves the block two clock cycles after it enters, with its own output valid strobe.

Top module: `chmap_softmute`

## Requirements
- R1: The left output source comes from `map_code[1:0]`: 2'b00 gives zero, 2'b01 gives the right input, 2'b10 gives the left input, and 2'b11 gives the average of both inputs.
- R2: The right output source comes from `map_code[3:2]` and uses the same four encodings as R1.
- R3: The average equals the floor of (left + right) / 2, computed as a sum one bit wider than the samples with an arithmetic shift right by one bit. It never overflows, including when both inputs are at the most positive value or both are at the most negative value.
- R4: `out_valid` is high exactly two clock cycles after each cycle with `in_valid` high, and low in every other cycle.
- R5: `map_code` and `mute_req` are sampled only in cycles where `in_valid` is high. Changing them in other cycles has no effect on any output.
- R6: After reset, `out_valid` and both outputs are zero and the gain is full scale, so the first frames pass through exactly as mapped.
- R7: Each output equals floor(mapped × g / 256), where g is the gain held when the frame was accepted (0 to 256). A frame accepted with `mute_req` high lowers g by 1, stopping at 0. A full fade takes 256 frames, and after that every output is zero.
- R8: A frame accepted with `mute_req` low raises g by 1, stopping at 256. At g = 256 the output equals the mapped sample exactly.
- R9: If `mute_req` changes while a ramp is in progress, the gain changes direction on the very next frame, starting from the value it had reached.
- R10: The gain never changes in a cycle without a valid frame, and it moves by at most one step per frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame is present on the sample inputs this cycle |
| in_left | input | W (24) | Left input sample, two's complement |
| in_right | input | W (24) | Right input sample, two's complement |
| map_code | input | 4 | Source fields: [1:0] for the left output, [3:2] for the right output |
| mute_req | input | 1 | High fades the output to zero; low fades it back to full scale |
| out_valid | output | 1 | Output frame strobe |
| out_left | output | W (24) | Left output sample |
| out_right | output | W (24) | Right output sample |

## Verification
The bench walks through all sixteen mapping codes using extreme samples, including both inputs at the most positive and at the most negative value. A design whose average loses the carry bit would flip the sign of its mono output. A design that rounds toward zero would be off by one on odd negative sums. The bench toggles the mapping code and the mute request in cycles without a frame. A design that samples them there would either route the frame through the wrong source or shift the gain with no frame present.

The bench runs a full fade to zero, a partial return, a reversal in mid-ramp and a full return. Its behavioural gain model is compared against the outputs on every frame. A ramp with the wrong step size or a wrong end stop shows up as an off-by-one output. A ramp that finishes its current direction before reversing shows up the same way.

// File: rtl/chm_pkg.sv
package chm_pkg;
   // Source choice for one output channel, decoded from a 2-bit field.
   typedef enum logic [1:0] {
      SRC_SILENT = 2'b00,
      SRC_RIGHT  = 2'b01,
      SRC_LEFT   = 2'b10,
      SRC_MIX    = 2'b11
   } src_e;

   localparam int NUM_CH = 2;
   localparam int FIELD_W = 2;
endpackage

// File: rtl/chm_source_sel.sv
module chm_source_sel
   import chm_pkg::*;
#(
   parameter int W = 24,
   parameter bit MIX_ROUND = 1'b0  // 0: floor average, 1: round half up
) (
   input  src_e                sel,
   input  logic signed [W-1:0] in_l,
   input  logic signed [W-1:0] in_r,
   output logic signed [W-1:0] y
);
   localparam int SUM_W = W + 1;

   logic signed [SUM_W-1:0] sum;
   logic signed [W-1:0]     mix;

   // A sum one bit wider than the samples cannot overflow.
   assign sum = {in_l[W-1], in_l} + {in_r[W-1], in_r};

   generate
      if (MIX_ROUND) begin : g_mix_round
         logic signed [SUM_W:0] sum_r;
         assign sum_r = {sum[SUM_W-1], sum} + {{SUM_W{1'b0}}, 1'b1};
         assign mix   = sum_r[W:1];
      end else begin : g_mix_floor
         // Dropping the LSB of a two's complement value is a floor divide.
         assign mix = sum[W:1];
      end
   endgenerate

   always_comb begin
      unique case (sel)
         SRC_SILENT: y = '0;
         SRC_RIGHT:  y = in_r;
         SRC_LEFT:   y = in_l;
         SRC_MIX:    y = mix;
         default:    y = '0;
      endcase
   end
endmodule

// File: rtl/chm_gain_ramp.sv
module chm_gain_ramp #(
   parameter int GAIN_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  logic              mute,
   output logic [GAIN_W:0]   gain
);
   localparam logic [GAIN_W:0] FULL = {1'b1, {GAIN_W{1'b0}}};
   localparam logic [GAIN_W:0] ONE  = {{GAIN_W{1'b0}}, 1'b1};

   logic [GAIN_W:0] gain_q;
   logic [GAIN_W:0] gain_nxt;

   // Target follows the mute request sampled with each frame, so a
   // request change mid-ramp reverses the direction at once.
   always_comb begin
      gain_nxt = gain_q;
      if (step_en) begin
         if (mute) begin
            if (gain_q != '0) gain_nxt = gain_q - ONE;
         end else begin
            if (gain_q != FULL) gain_nxt = gain_q + ONE;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) gain_q <= FULL;
      else        gain_q <= gain_nxt;
   end

   assign gain = gain_q;
endmodule

// File: rtl/chm_gain_apply.sv
module chm_gain_apply #(
   parameter int W      = 24,
   parameter int GAIN_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic signed [W-1:0] x,
   input  logic [GAIN_W:0]     gain,
   output logic signed [W-1:0] y
);
   localparam int PROD_W = W + GAIN_W + 2;

   logic signed [GAIN_W+1:0] gain_s;
   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] scaled;

   assign gain_s = $signed({1'b0, gain});
   assign prod   = PROD_W'(x) * PROD_W'(gain_s);
   // Arithmetic shift floors the result; gain of full scale is exact.
   assign scaled = prod >>> GAIN_W;

   always_ff @(posedge clk) begin
      if (!rst_n)  y <= '0;
      else if (en) y <= scaled[W-1:0];
   end
endmodule

// File: rtl/chmap_softmute.sv
module chmap_softmute
   import chm_pkg::*;
#(
   parameter int W         = 24,
   parameter int GAIN_W    = 8,
   parameter bit MIX_ROUND = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic signed [W-1:0] in_left,
   input  logic signed [W-1:0] in_right,
   input  logic [3:0]          map_code,
   input  logic                mute_req,
   output logic                out_valid,
   output logic signed [W-1:0] out_left,
   output logic signed [W-1:0] out_right
);
   localparam int CODE_W = NUM_CH * FIELD_W;

   generate
      if (W < 4 || W > 32) begin : g_bad_width
         $error("chmap_softmute: W must lie in 4..32");
      end
      if (GAIN_W < 1 || GAIN_W > 12) begin : g_bad_gain
         $error("chmap_softmute: GAIN_W must lie in 1..12");
      end
      if (CODE_W != 4) begin : g_bad_code
         $error("chmap_softmute: mapping code width mismatch");
      end
   endgenerate

   logic [GAIN_W:0]     gain_q;
   logic [GAIN_W:0]     s1_gain;
   logic                s1_valid;
   logic signed [W-1:0] mapped [NUM_CH];
   logic signed [W-1:0] s1_smp [NUM_CH];
   logic signed [W-1:0] scaled [NUM_CH];

   chm_gain_ramp #(.GAIN_W(GAIN_W)) u_ramp (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (in_valid),
      .mute    (mute_req),
      .gain    (gain_q)
   );

   // Stage 1: route per channel, capture frame and gain held for it.
   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         chm_source_sel #(.W(W), .MIX_ROUND(MIX_ROUND)) u_sel (
            .sel  (src_e'(map_code[FIELD_W*ch +: FIELD_W])),
            .in_l (in_left),
            .in_r (in_right),
            .y    (mapped[ch])
         );

         always_ff @(posedge clk) begin
            if (!rst_n)        s1_smp[ch] <= '0;
            else if (in_valid) s1_smp[ch] <= mapped[ch];
         end

         // Stage 2: soft-mute gain.
         chm_gain_apply #(.W(W), .GAIN_W(GAIN_W)) u_apply (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (s1_valid),
            .x     (s1_smp[ch]),
            .gain  (s1_gain),
            .y     (scaled[ch])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid  <= 1'b0;
         s1_gain   <= '0;
         out_valid <= 1'b0;
      end else begin
         s1_valid  <= in_valid;
         out_valid <= s1_valid;
         if (in_valid) s1_gain <= gain_q;
      end
   end

   assign out_left  = scaled[0];
   assign out_right = scaled[1];
endmodule

// File: rtl/chm_checker.sv
module chm_checker #(
   parameter int W      = 24,
   parameter int GAIN_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic [3:0]          map_code,
   input logic                mute_req,
   input logic                out_valid,
   input logic signed [W-1:0] out_left,
   input logic signed [W-1:0] out_right,
   input logic [GAIN_W:0]     gain
);
   localparam logic [GAIN_W:0] FULL = {1'b1, {GAIN_W{1'b0}}};
   localparam logic [GAIN_W:0] ONE  = {{GAIN_W{1'b0}}, 1'b1};

   p_valid_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 out_valid);
   p_valid_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 2));
   p_silence_left_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(map_code[1:0], 2) == 2'b00) |-> out_left == '0);
   p_silence_right_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(map_code[3:2], 2) == 2'b00) |-> out_right == '0);
   p_gain_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(gain));
   p_gain_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mute_req && gain != '0) |=> gain == $past(gain) - ONE);
   p_gain_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mute_req && gain == '0) |=> gain == '0);
   p_gain_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !mute_req && gain != FULL) |=> gain == $past(gain) + ONE);
   p_gain_ceiling_r8: assert property (@(posedge clk) disable iff (!rst_n)
      gain <= FULL);
endmodule

bind chmap_softmute chm_checker #(.W(W), .GAIN_W(GAIN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .map_code  (map_code),
   .mute_req  (mute_req),
   .out_valid (out_valid),
   .out_left  (out_left),
   .out_right (out_right),
   .gain      (gain_q)
);

// File: tb/sim_chmap_softmute.sv
module sim_chmap_softmute;
   localparam int W          = 24;
   localparam int CLK_PERIOD = 10;
   localparam longint FULL   = 256;
   localparam longint SMAX   = (64'sd1 <<< (W - 1)) - 1;
   localparam longint SMIN   = -(64'sd1 <<< (W - 1));

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                in_valid = 1'b0;
   logic signed [W-1:0] in_left = '0;
   logic signed [W-1:0] in_right = '0;
   logic [3:0]          map_code = 4'b0000;
   logic                mute_req = 1'b0;
   logic                out_valid;
   logic signed [W-1:0] out_left;
   logic signed [W-1:0] out_right;

   always #(CLK_PERIOD / 2) clk = ~clk;

   chmap_softmute #(.W(W)) u0 (
      .clk, .rst_n, .in_valid, .in_left, .in_right,
      .map_code, .mute_req, .out_valid, .out_left, .out_right
   );

   typedef struct {
      int     due;
      longint l;
      longint r;
      string  tag;
   } exp_t;

   exp_t   q[$];
   int     n_chk = 0;
   int     n_fail = 0;
   int     step_idx = 0;
   longint g_model = FULL;
   bit     done = 1'b0;

   task automatic check(bit ok, string tag, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic longint pick(logic [1:0] s, longint l, longint r);
      case (s)
         2'b00:   return 0;
         2'b01:   return r;
         2'b10:   return l;
         default: return (l + r) >>> 1;
      endcase
   endfunction

   // Advance to the next falling edge and compare the outputs there.
   task automatic tick();
      @(negedge clk);
      step_idx++;
      if (q.size() > 0 && q[0].due == step_idx) begin
         exp_t e = q.pop_front();
         check(out_valid == 1'b1, "R4", "out_valid on frame", longint'(out_valid), 1);
         check(longint'(out_left) == e.l, e.tag, "out_left", longint'(out_left), e.l);
         check(longint'(out_right) == e.r, e.tag, "out_right", longint'(out_right), e.r);
      end else begin
         check(out_valid == 1'b0, "R4", "out_valid idle", longint'(out_valid), 0);
      end
   endtask

   task automatic send(longint l, longint r, logic [3:0] code, bit mute, string tag);
      exp_t e;
      tick();
      in_valid = 1'b1;
      in_left  = l[W-1:0];
      in_right = r[W-1:0];
      map_code = code;
      mute_req = mute;
      e.due = step_idx + 2;
      e.l   = (pick(code[1:0], l, r) * g_model) >>> 8;
      e.r   = (pick(code[3:2], l, r) * g_model) >>> 8;
      e.tag = tag;
      q.push_back(e);
      if (mute) begin
         if (g_model > 0) g_model--;
      end else begin
         if (g_model < FULL) g_model++;
      end
   endtask

   task automatic idle(logic [3:0] code, bit mute);
      tick();
      in_valid = 1'b0;
      map_code = code;
      mute_req = mute;
   endtask

   function automatic longint rnd();
      logic signed [W-1:0] v = W'($urandom);
      return longint'(v);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R4 watchdog actual=%0d expected=%0d", step_idx, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      // R6: reset state
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R6", "out_valid in reset", longint'(out_valid), 0);
      check(out_left == '0, "R6", "out_left in reset", longint'(out_left), 0);
      check(out_right == '0, "R6", "out_right in reset", longint'(out_right), 0);
      rst_n = 1'b1;

      // R6/R1/R2: stereo passthrough at full gain straight after reset
      for (int i = 0; i < 8; i++) send(rnd(), rnd(), 4'b0110, 1'b0, "R6");

      // R1, R2, R3: every code against extreme and random pairs
      for (int c = 0; c < 16; c++) begin
         send(SMAX, SMAX, 4'(c), 1'b0, "R3");
         send(SMIN, SMIN, 4'(c), 1'b0, "R3");
         send(SMAX, SMIN, 4'(c), 1'b0, "R3");
         send(-3, 0, 4'(c), 1'b0, "R3");
         send(rnd(), rnd(), 4'(c), 1'b0, "R1");
         send(rnd(), rnd(), 4'(c), 1'b0, "R2");
      end

      // R5: code and mute wiggle between gapped frames
      for (int i = 0; i < 20; i++) begin
         send(rnd(), rnd(), 4'b1001, 1'b0, "R5");
         idle(4'b0000, 1'b1);
         idle(4'b1111, 1'b1);
      end

      // R7: full fade to zero and beyond
      for (int i = 0; i < 300; i++) send(SMAX, rnd(), 4'b1110, 1'b1, "R7");
      // R8: partial return, then R9: reversal mid-ramp
      for (int i = 0; i < 120; i++) send(rnd(), rnd(), 4'b0110, 1'b0, "R8");
      for (int i = 0; i < 40; i++) send(rnd(), rnd(), 4'b0110, 1'b1, "R9");
      for (int i = 0; i < 10; i++) send(rnd(), rnd(), 4'b1101, 1'b0, "R9");
      // R8: climb back to full scale and hold there
      for (int i = 0; i < 300; i++) send(rnd(), SMIN, 4'b0110, 1'b0, "R8");
      // R10: long idle stretch with mute high, then a frame at full gain
      for (int i = 0; i < 30; i++) idle(4'b0110, 1'b1);
      send(SMAX, SMIN, 4'b0110, 1'b0, "R10");

      for (int i = 0; i < 4; i++) idle(4'b0000, 1'b0);
      check(q.size() == 0, "R4", "frames left unseen", longint'(q.size()), 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule